// File: doc/BRIEF.md
# Late-Write Buffer with Read Forwarding

This block sits between the command decoder of a pipelined static RAM and its storage array. A write command carries its address, and the data for that write arrives one cycle later. The block does not write the array while the data is still in flight. It keeps the address and data in a single-entry buffer, and it copies that entry into the array only when the next write command comes in. Every read is compared with the buffered entry, one half-word at a time. A half that the buffer holds is returned from the buffer and not from the array, so a read may follow a write in the very next cycle and still see the new data.

The array is organised as rows of two half-words. Bit 0 of the command address selects the half and the upper bits select the row. A two-beat (DDR) access covers both halves of a row: beat 0 maps to the addressed half and beat 1 maps to the other half. A one-beat (SDR) access covers only the addressed half. Both beats of a DDR write arrive together, on two data ports, in the cycle after the command. Edge-level I/O timing is left to the pad logic.

The array port is synchronous. Read data returns one cycle after `mem_re`, and a write takes effect at the clock edge on which `mem_we` is high.

Top module: `late_write_buf`

## Requirements
- R1: The read result appears on `rd_valid`/`rd_beat0`/`rd_beat1` exactly one cycle after the read command. `rd_beat0` carries the addressed half. For a DDR read, `rd_beat1` carries the other half of the same row and `rd_ddr` is 1. For an SDR read, `rd_beat1` is 0 and `rd_ddr` is 0.
- R2: Write data is sampled only in the cycle right after a write command. `wr_beat0` fills the addressed half, and for a DDR write `wr_beat1` fills the other half. Values on the write data ports in any other cycle have no effect.
- R3: A write command does not write the array itself. Its entry is written (`mem_we` high, row = address bits AW-1:1, half 0 in `mem_wdata` bits DW-1:0 and half 1 above them) during the cycle of the next write command.
- R4: A read whose row matches the buffered row takes each half the buffer holds from the buffer, and takes the remaining halves from the array.
- R5: A read issued in the cycle right after a write to the same address returns the new write data, with no idle cycle in between.
- R6: An SDR write commits only the half it addresses: `mem_wmask` is one-hot (bit 0 = half 0, bit 1 = half 1), and the other half of that row in the array keeps its value.
- R7: When two writes come back to back, the older entry is committed with its data in the cycle its data arrives, and the newer entry becomes the buffered one.
- R8: After reset the buffer is empty. The first write command raises no `mem_we`, and no read is served from the buffer.
- R9: `mem_re` is high exactly in the cycles that carry a read command, with `mem_rrow` set to that command's row. `mem_re` and `mem_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ddr | input | 1 | 1 = two-beat access, 0 = one beat |
| cmd_addr | input | AW | Half-word address; bit 0 selects the half |
| wr_beat0 | input | DW | First write beat, valid in the cycle after a write command |
| wr_beat1 | input | DW | Second write beat (DDR only), same cycle as `wr_beat0` |
| mem_we | output | 1 | Array write strobe |
| mem_wrow | output | AW-1 | Array write row |
| mem_wmask | output | 2 | Per-half write enables |
| mem_wdata | output | 2*DW | Array write data, half 1 in the upper part |
| mem_re | output | 1 | Array read strobe |
| mem_rrow | output | AW-1 | Array read row |
| mem_rdata | input | 2*DW | Array read data, one cycle after `mem_re` |
| rd_valid | output | 1 | Read result valid |
| rd_ddr | output | 1 | Read result carries two beats |
| rd_beat0 | output | DW | Read beat 0 (addressed half) |
| rd_beat1 | output | DW | Read beat 1 (other half, DDR only) |

## Verification
The bench builds the block with AW = 6 and DW = 8, which gives 32 rows of two bytes and a behavioural array small enough to preload in full. Its mixed traffic phase draws addresses from a 16-half window. Reads therefore land often on the buffered row while it is half filled, full, or in the middle of a commit, and they also land in the cycle right after a write. Directed cases pin down the commit timing for the back-to-back, single-half and cross-half cases.

// File: rtl/late_write_buf.sv
module late_write_buf #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_write,
  input  logic            cmd_ddr,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   wr_beat0,
  input  logic [DW-1:0]   wr_beat1,
  output logic            mem_we,
  output logic [AW-2:0]   mem_wrow,
  output logic [1:0]      mem_wmask,
  output logic [2*DW-1:0] mem_wdata,
  output logic            mem_re,
  output logic [AW-2:0]   mem_rrow,
  input  logic [2*DW-1:0] mem_rdata,
  output logic            rd_valid,
  output logic            rd_ddr,
  output logic [DW-1:0]   rd_beat0,
  output logic [DW-1:0]   rd_beat1
);
  localparam int RW = AW - 1;

  logic [RW-1:0] buf_row;
  logic [1:0]    buf_val;
  logic [DW-1:0] buf_d0, buf_d1;
  logic          pend, pend_ddr, pend_half;

  logic          rd_q, rd_ddr_q, rd_half;
  logic [RW-1:0] rd_row;

  logic [1:0]    fill, cur_val, hit;
  logic [DW-1:0] cur_d0, cur_d1, h0, h1;

  wire wr_cmd = cmd_valid & cmd_write;
  wire rd_cmd = cmd_valid & ~cmd_write;

  // entry as seen this cycle, including beats arriving now
  always_comb begin
    fill    = pend_ddr ? 2'b11 : (pend_half ? 2'b10 : 2'b01);
    cur_val = pend ? fill : buf_val;
    cur_d0  = buf_d0;
    cur_d1  = buf_d1;
    if (pend) begin
      if (fill[0]) cur_d0 = pend_half ? wr_beat1 : wr_beat0;
      if (fill[1]) cur_d1 = pend_half ? wr_beat0 : wr_beat1;
    end
  end

  assign mem_we    = wr_cmd & (|cur_val);
  assign mem_wrow  = buf_row;
  assign mem_wmask = cur_val;
  assign mem_wdata = {cur_d1, cur_d0};
  assign mem_re    = rd_cmd;
  assign mem_rrow  = cmd_addr[AW-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_row   <= '0;
      buf_val   <= 2'b00;
      buf_d0    <= '0;
      buf_d1    <= '0;
      pend      <= 1'b0;
      pend_ddr  <= 1'b0;
      pend_half <= 1'b0;
    end else begin
      buf_d0 <= cur_d0;
      buf_d1 <= cur_d1;
      pend   <= wr_cmd;
      if (wr_cmd) begin
        buf_row   <= cmd_addr[AW-1:1];
        buf_val   <= 2'b00;
        pend_ddr  <= cmd_ddr;
        pend_half <= cmd_addr[0];
      end else begin
        buf_val <= cur_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      rd_ddr_q <= 1'b0;
      rd_half  <= 1'b0;
      rd_row   <= '0;
    end else begin
      rd_q <= rd_cmd;
      if (rd_cmd) begin
        rd_ddr_q <= cmd_ddr;
        rd_half  <= cmd_addr[0];
        rd_row   <= cmd_addr[AW-1:1];
      end
    end
  end

  assign hit = (buf_row == rd_row) ? cur_val : 2'b00;
  assign h0  = hit[0] ? cur_d0 : mem_rdata[DW-1:0];
  assign h1  = hit[1] ? cur_d1 : mem_rdata[2*DW-1:DW];

  assign rd_valid = rd_q;
  assign rd_ddr   = rd_q & rd_ddr_q;
  assign rd_beat0 = rd_half ? h1 : h0;
  assign rd_beat1 = (rd_q & rd_ddr_q) ? (rd_half ? h0 : h1) : '0;

  a_r1_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !cmd_write));
  a_r1_sdr_beat1_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ddr) |-> (rd_beat1 == '0));
  a_r9_no_rw_collision: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  a_r3_commit_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cmd_valid && cmd_write && mem_wmask != 2'b00));
  a_r2_beats_follow_write: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> $past(cmd_valid && cmd_write));
endmodule

// File: tb/tb_late_write_buf.sv
module tb_late_write_buf;
  localparam int AW = 6, DW = 8, RW = AW - 1, NR = 1 << RW, NA = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_valid, cmd_write, cmd_ddr;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wr_beat0, wr_beat1, rd_beat0, rd_beat1;
  logic mem_we, mem_re, rd_valid, rd_ddr;
  logic [RW-1:0] mem_wrow, mem_rrow;
  logic [1:0] mem_wmask;
  logic [2*DW-1:0] mem_wdata, mem_rdata;

  late_write_buf #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_ddr(cmd_ddr), .cmd_addr(cmd_addr), .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
    .mem_we(mem_we), .mem_wrow(mem_wrow), .mem_wmask(mem_wmask), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rrow(mem_rrow), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_ddr(rd_ddr), .rd_beat0(rd_beat0), .rd_beat1(rd_beat1));

  logic [2*DW-1:0] arr [NR];
  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_wmask[0]) arr[mem_wrow][DW-1:0] <= mem_wdata[DW-1:0];
      if (mem_wmask[1]) arr[mem_wrow][2*DW-1:DW] <= mem_wdata[2*DW-1:DW];
    end
    if (mem_re) mem_rdata <= arr[mem_rrow];
  end

  int checks = 0, failures = 0;
  logic [DW-1:0] expv [NA];
  logic [15:0] lf = 16'hACE1;
  logic pw = 1'b0;
  logic [DW-1:0] pb0, pb1;
  logic rq = 1'b0, rq_ddr;
  logic [DW-1:0] rq_b0, rq_b1;
  string rq_tag;
  logic c_we, c_re;
  logic [1:0] c_mask;
  logic [RW-1:0] c_row;
  logic [2*DW-1:0] c_wdata;

  function automatic logic [DW-1:0] initv(input int i);
    return DW'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic d, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_valid = v; cmd_write = w; cmd_ddr = d; cmd_addr = a;
    if (pw) begin wr_beat0 = pb0; wr_beat1 = pb1; end
    else begin wr_beat0 = lf[7:0]; wr_beat1 = lf[15:8]; end
    pw = 1'b0;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    #1;
    c_we = mem_we; c_re = mem_re; c_mask = mem_wmask; c_row = mem_wrow; c_wdata = mem_wdata;
    if (c_we && c_re) chk("R9 collision", 1, 0);
    chk("R9 mem_re", {31'd0, c_re}, {31'd0, v & ~w});
    if (v && !w) chk("R9 mem_rrow", 32'(mem_rrow), 32'(a[AW-1:1]));
    if (rq) begin
      chk({rq_tag, " rd_valid"}, {31'd0, rd_valid}, 1);
      chk({rq_tag, " rd_ddr"}, {31'd0, rd_ddr}, {31'd0, rq_ddr});
      chk({rq_tag, " beat0"}, 32'(rd_beat0), 32'(rq_b0));
      chk({rq_tag, " beat1"}, 32'(rd_beat1), 32'(rq_b1));
      rq = 1'b0;
    end else if (v || w) begin
      chk("R1 rd_valid low", {31'd0, rd_valid}, 0);
    end
  endtask

  task automatic do_wr(input logic d, input logic [AW-1:0] a, input logic [DW-1:0] b0, input logic [DW-1:0] b1);
    cyc(1'b1, 1'b1, d, a);
    pw = 1'b1; pb0 = b0; pb1 = b1;
    expv[a] = b0;
    if (d) expv[a ^ AW'(1)] = b1;
  endtask

  task automatic do_rd(input logic d, input logic [AW-1:0] a, input string tag);
    cyc(1'b1, 1'b0, d, a);
    rq = 1'b1; rq_ddr = d; rq_tag = tag;
    rq_b0 = expv[a];
    rq_b1 = d ? expv[a ^ AW'(1)] : '0;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_reset_and_hit();
    chk("R8 rd_valid after reset", {31'd0, rd_valid}, 0);
    do_wr(1'b1, 6'd5, 8'hA1, 8'hB2);
    chk("R8 no commit on first write", {31'd0, c_we}, 0);
    do_rd(1'b1, 6'd5, "R5");
    idle();
    chk("R3 array untouched", 32'(arr[2]), 32'({initv(5), initv(4)}));
  endtask

  task automatic t_commit();
    do_wr(1'b0, 6'd10, 8'hC3, 8'h00);
    chk("R3 we", {31'd0, c_we}, 1);
    chk("R3 row", 32'(c_row), 2);
    chk("R3 mask", 32'(c_mask), 3);
    chk("R3 data", 32'(c_wdata), 32'h0000A1B2);
    idle();
    chk("R3 array after commit", 32'(arr[2]), 32'h0000A1B2);
    do_rd(1'b0, 6'd10, "R4");
    do_rd(1'b0, 6'd11, "R6 miss half");
    do_rd(1'b1, 6'd11, "R4 mixed");
    idle();
  endtask

  task automatic t_back_to_back();
    do_wr(1'b1, 6'd20, 8'h11, 8'h22);
    chk("R6 sdr mask", 32'(c_mask), 1);
    chk("R6 sdr row", 32'(c_row), 5);
    chk("R6 sdr data", 32'(c_wdata[DW-1:0]), 32'hC3);
    do_wr(1'b0, 6'd21, 8'h33, 8'h5A);
    chk("R7 we", {31'd0, c_we}, 1);
    chk("R7 row", 32'(c_row), 10);
    chk("R7 mask", 32'(c_mask), 3);
    chk("R7 data", 32'(c_wdata), 32'h00002211);
    do_rd(1'b1, 6'd20, "R7 merge");
    idle();
    do_wr(1'b0, 6'd40, 8'h44, 8'h00);
    chk("R6 half1 mask", 32'(c_mask), 2);
    chk("R6 half1 data", 32'(c_wdata[2*DW-1:DW]), 32'h33);
    idle();
    chk("R6 other half kept", 32'(arr[10]), 32'h00003311);
  endtask

  task automatic t_ignore_data();
    idle(); idle(); idle();
    do_rd(1'b1, 6'd40, "R2");
    idle();
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 400; i++) begin
      logic [15:0] r;
      r = lf;
      case (r[1:0])
        2'd0, 2'd1: do_wr(r[14], {2'b00, r[5:2]}, r[13:6], r[11:4]);
        2'd2: do_rd(r[14], {2'b00, r[5:2]}, "R1");
        default: idle();
      endcase
    end
    idle();
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) expv[i] = initv(i);
    for (int r = 0; r < NR; r++) arr[r] = {initv(2 * r + 1), initv(2 * r)};
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_ddr = 1'b0;
    cmd_addr = '0; wr_beat0 = '0; wr_beat1 = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_and_hit();
    t_commit();
    t_back_to_back();
    t_ignore_data();
    t_mixed();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule